// File: doc/BRIEF.md
# Stepper Motor Phase Sequencer

This block drives the four coil lines of a two-phase stepper motor from a single-cycle step request and a direction bit. It keeps a two-bit phase position. Each accepted step moves the position one place, either forward or backward. The coil outputs then take the energising pattern for the new position. The patterns use full stepping with two coils energised at a time.

After each step the block waits a programmable number of clock cycles so the rotor can settle. During that wait it raises `busy`, and it drops any request that arrives. Reset parks the position at zero. When reset is released, the block runs a homing burst of four forward steps on its own, to bring the driver into line with the rotor. Each of those steps is followed by the same settling wait.

`step_req` is a plain control strobe with no back-pressure handshake. The block samples it on every rising edge. A request counts only on an edge where `busy` is low. When `busy` is high the request is dropped, not queued, and the requester must offer it again after `busy` falls.

Top module: `stepper_phase_seq`

## Requirements
- R1: The coil vector {coil_a, coil_b, coil_a_n, coil_b_n} depends only on the phase position. Position 0 gives 1100, 1 gives 0110, 2 gives 0011 and 3 gives 1001, so exactly two coils are on at any time.
- R2: An accepted request with step_dir = 0 (clockwise) moves the position to (position + 1) mod 4.
- R3: An accepted request with step_dir = 1 (counter-clockwise) moves the position to (position + 3) mod 4.
- R4: After the edge on which a step is taken, busy is high for exactly SETTLE_CYCLES cycles and then falls. Two steps are therefore never closer than SETTLE_CYCLES + 1 cycles apart.
- R5: A request made while busy is high is ignored. No step_done pulse follows it and the coils do not change.
- R6: The coil outputs are registered. They change only on the edge that takes a step, and step_done is high for exactly the one cycle after that edge.
- R7: While reset is held (rst_n low), the coils read 1100, busy is high, and step_done and sync_done are low.
- R8: After reset is released, the block takes four clockwise steps without any request. The first is on the first rising edge and the rest follow at intervals of SETTLE_CYCLES + 1 cycles, giving coils 0110, 0011, 1001, 1100. Busy stays high for the whole burst.
- R9: sync_done pulses for one cycle together with the step_done of the fourth homing step, and never after a requested step.
- R10: A request seen on a rising edge while busy is low is taken on that edge, with step_done high in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| step_req | input | 1 | Step request strobe |
| step_dir | input | 1 | Direction for the request: 0 clockwise, 1 counter-clockwise |
| coil_a | output | 1 | Coil A drive |
| coil_b | output | 1 | Coil B drive |
| coil_a_n | output | 1 | Coil A-bar drive |
| coil_b_n | output | 1 | Coil B-bar drive |
| busy | output | 1 | High while a settling wait or the homing burst is in progress |
| step_done | output | 1 | One-cycle pulse after each step is taken |
| sync_done | output | 1 | One-cycle pulse marking the last homing step |

## Verification
Taking a step costs one register stage. The coils and `step_done` are therefore due in the first cycle after the edge that sampled an accepted request. `busy` then stays high for SETTLE_CYCLES samples and is due low on the next one. Homing steps are due on edge 1 and every SETTLE_CYCLES + 1 edges after that. The bench drives inputs and samples outputs on the falling edge, counting edges one by one from the accepting edge, so each comparison falls in the exact cycle its result is due. Requests made during a settling wait are followed by the same per-cycle checks, which confirm that no step appears.

// File: rtl/stepper_seq_pkg.sv
package stepper_seq_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE   = 2'd0,
    SQ_ISSUE  = 2'd1,
    SQ_SETTLE = 2'd2
  } sq_state_t;

  localparam int PH_W = 2;

endpackage

// File: rtl/phase_advance.sv
module phase_advance #(
  parameter int PW = 2
) (
  input  logic [PW-1:0] pos_i,
  input  logic          rev_i,
  output logic [PW-1:0] pos_o
);
  localparam logic [PW-1:0] FWD = PW'(1);
  localparam logic [PW-1:0] REV = PW'((1 << PW) - 1);

  // reverse motion adds (N-1) modulo N rather than subtracting
  always_comb pos_o = pos_i + (rev_i ? REV : FWD);
endmodule

// File: rtl/coil_pattern_map.sv
module coil_pattern_map #(
  parameter int PW = 2
) (
  input  logic [PW-1:0] pos_i,
  output logic [3:0]    coils_o
);
  localparam logic [3:0] BASE = 4'b1100;
  logic [7:0] dbl;

  // each row is the base two-on pattern rotated right by the position
  always_comb begin
    dbl     = {BASE, BASE} >> pos_i;
    coils_o = dbl[3:0];
  end
endmodule

// File: rtl/settle_timer.sv
module settle_timer #(
  parameter int unsigned CYCLES = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  output logic zero_o
);
  localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
  localparam logic [CW-1:0] TOP = CW'(CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)           cnt <= '0;
    else if (load_i)      cnt <= TOP;
    else if (cnt != '0)   cnt <= cnt - CW'(1);
  end

  assign zero_o = (cnt == '0);
endmodule

// File: rtl/stepper_phase_seq.sv
module stepper_phase_seq
  import stepper_seq_pkg::*;
#(
  parameter int unsigned SETTLE_CYCLES = 10_000_000,
  parameter int unsigned SYNC_STEPS    = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step_req,
  input  logic step_dir,
  output logic coil_a,
  output logic coil_b,
  output logic coil_a_n,
  output logic coil_b_n,
  output logic busy,
  output logic step_done,
  output logic sync_done
);
  localparam int SYNC_W = $clog2(SYNC_STEPS + 1);

  sq_state_t       state;
  logic [PH_W-1:0] pos, pos_nxt;
  logic [3:0]      coils, coils_nxt;
  logic [SYNC_W-1:0] sync_left;
  logic            take, rev, tmr_zero;

  // homing steps are always clockwise
  assign rev  = (state == SQ_ISSUE) ? 1'b0 : step_dir;
  assign take = (state == SQ_ISSUE) || (state == SQ_IDLE && step_req);

  phase_advance #(.PW(PH_W)) adv_i (
    .pos_i (pos),
    .rev_i (rev),
    .pos_o (pos_nxt)
  );

  coil_pattern_map #(.PW(PH_W)) map_i (
    .pos_i   (pos_nxt),
    .coils_o (coils_nxt)
  );

  settle_timer #(.CYCLES(SETTLE_CYCLES)) tmr_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (take),
    .zero_o (tmr_zero)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= SQ_ISSUE;
      pos       <= '0;
      coils     <= 4'b1100;
      sync_left <= SYNC_W'(SYNC_STEPS);
      step_done <= 1'b0;
      sync_done <= 1'b0;
    end else begin
      step_done <= 1'b0;
      sync_done <= 1'b0;
      if (take) begin
        pos       <= pos_nxt;
        coils     <= coils_nxt;
        step_done <= 1'b1;
        state     <= SQ_SETTLE;
      end
      if (state == SQ_ISSUE) begin
        sync_left <= sync_left - SYNC_W'(1);
        sync_done <= (sync_left == SYNC_W'(1));
      end
      if (state == SQ_SETTLE && tmr_zero)
        state <= (sync_left != '0) ? SQ_ISSUE : SQ_IDLE;
    end
  end

  assign busy = (state != SQ_IDLE);
  assign {coil_a, coil_b, coil_a_n, coil_b_n} = coils;
endmodule

// File: rtl/stepper_phase_seq_chk.sv
module stepper_phase_seq_chk #(
  parameter int unsigned SETTLE_CYCLES = 10
) (
  input logic clk,
  input logic rst_n,
  input logic step_req,
  input logic step_dir,
  input logic coil_a,
  input logic coil_b,
  input logic coil_a_n,
  input logic coil_b_n,
  input logic busy,
  input logic step_done,
  input logic sync_done
);
  logic [3:0]  cv;
  logic [31:0] gap;
  logic        seen;

  assign cv = {coil_a, coil_b, coil_a_n, coil_b_n};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap  <= '0;
      seen <= 1'b0;
    end else if (step_done) begin
      gap  <= 32'd1;
      seen <= 1'b1;
    end else if (gap != 32'hFFFF_FFFF) begin
      gap <= gap + 32'd1;
    end
  end

  AST_TWO_COILS_ON: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(cv) == 2) && (cv != 4'b1010) && (cv != 4'b0101)); // R1
  AST_CW_ROTATES: assert property (@(posedge clk) disable iff (!rst_n)
    (step_req && !busy && !step_dir) |=> cv == {$past(cv[0]), $past(cv[3:1])}); // R2
  AST_CCW_ROTATES: assert property (@(posedge clk) disable iff (!rst_n)
    (step_req && !busy && step_dir) |=> cv == {$past(cv[2:0]), $past(cv[3])}); // R3
  AST_STEP_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (step_done && seen) |-> gap >= SETTLE_CYCLES + 1); // R4
  AST_BUSY_AFTER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    step_done |-> busy); // R4
  AST_COILS_ONLY_ON_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cv) |-> step_done); // R6
  AST_SYNC_WITH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    sync_done |-> step_done); // R9
  AST_IDLE_REQ_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (step_req && !busy) |=> step_done); // R10
endmodule

bind stepper_phase_seq stepper_phase_seq_chk #(.SETTLE_CYCLES(SETTLE_CYCLES)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .step_req  (step_req),
  .step_dir  (step_dir),
  .coil_a    (coil_a),
  .coil_b    (coil_b),
  .coil_a_n  (coil_a_n),
  .coil_b_n  (coil_b_n),
  .busy      (busy),
  .step_done (step_done),
  .sync_done (sync_done)
);

// File: tb/stepper_phase_seq_tb.sv
`timescale 1ns/1ps
module stepper_phase_seq_tb_top;
  localparam int W = 5;

  logic clk = 1'b0;
  logic rst_n, step_req, step_dir;
  logic coil_a, coil_b, coil_a_n, coil_b_n, busy, step_done, sync_done;
  int   n_chk = 0;
  int   n_bad = 0;
  int   exp_pos = 0;

  always #2.5 clk = ~clk;

  stepper_phase_seq #(.SETTLE_CYCLES(W), .SYNC_STEPS(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .step_req(step_req), .step_dir(step_dir),
    .coil_a(coil_a), .coil_b(coil_b), .coil_a_n(coil_a_n), .coil_b_n(coil_b_n),
    .busy(busy), .step_done(step_done), .sync_done(sync_done)
  );

  function automatic logic [3:0] pat(input int p);
    case (p % 4)
      0: return 4'b1100;
      1: return 4'b0110;
      2: return 4'b0011;
      default: return 4'b1001;
    endcase
  endfunction

  function automatic logic [3:0] cv();
    return {coil_a, coil_b, coil_a_n, coil_b_n};
  endfunction

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic do_step(input bit dir, input bit poke);
    step_req = 1'b1;
    step_dir = dir;
    @(negedge clk);
    step_req = 1'b0;
    exp_pos = dir ? (exp_pos + 3) % 4 : (exp_pos + 1) % 4;
    check(step_done === 1'b1, "R10 step_done", 32'(step_done), 1);
    check(cv() === pat(exp_pos), dir ? "R3 coils" : "R2 coils", 32'(cv()), 32'(pat(exp_pos)));
    check(sync_done === 1'b0, "R9 no sync_done", 32'(sync_done), 0);
    check(busy === 1'b1, "R4 busy rises", 32'(busy), 1);
    for (int i = 1; i <= W; i++) begin
      step_req = poke & 1'($urandom_range(0, 1));
      step_dir = 1'($urandom_range(0, 1));
      @(negedge clk);
      check(busy === (i < W), "R4 busy window", 32'(busy), 32'(i < W));
      check(step_done === 1'b0, "R5 no step", 32'(step_done), 0);
      check(cv() === pat(exp_pos), "R5 coils held", 32'(cv()), 32'(pat(exp_pos)));
    end
    step_req = 1'b0;
  endtask

  initial begin
    #(5.0 * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd2718);
    rst_n = 1'b0; step_req = 1'b0; step_dir = 1'b0;
    repeat (3) @(negedge clk);
    step_req = 1'b1;
    @(negedge clk);
    check(cv() === 4'b1100, "R7 reset coils", 32'(cv()), 32'hC);
    check(busy === 1'b1, "R7 reset busy", 32'(busy), 1);
    check(step_done === 1'b0 && sync_done === 1'b0, "R7 reset pulses",
          {step_done, sync_done}, 0);
    step_req = 1'b0;
    rst_n = 1'b1;
    // homing burst
    for (int s = 1; s <= 4; s++) begin
      @(negedge clk);
      check(step_done === 1'b1, "R8 homing step", 32'(step_done), 1);
      check(cv() === pat(s), "R8 homing coils", 32'(cv()), 32'(pat(s)));
      check(sync_done === (s == 4), "R9 sync_done", 32'(sync_done), 32'(s == 4));
      check(busy === 1'b1, "R8 busy", 32'(busy), 1);
      if (s < 4) begin
        for (int i = 0; i < W; i++) begin
          @(negedge clk);
          check(busy === 1'b1 && step_done === 1'b0, "R8 burst wait",
                {busy, step_done}, 32'h2);
        end
      end
    end
    for (int i = 1; i <= W; i++) begin
      @(negedge clk);
      check(busy === (i < W), "R4 busy after homing", 32'(busy), 32'(i < W));
    end
    exp_pos = 0;
    // directed wraps
    for (int k = 0; k < 4; k++) do_step(1'b0, 1'b0);
    for (int k = 0; k < 5; k++) do_step(1'b1, 1'b1);
    do_step(1'b0, 1'b1);
    do_step(1'b1, 1'b0);
    // random mix
    for (int k = 0; k < 40; k++) begin
      int gap;
      gap = $urandom_range(0, 3);
      for (int g = 0; g < gap; g++) begin
        @(negedge clk);
        check(step_done === 1'b0 && cv() === pat(exp_pos), "R6 idle hold",
              32'(cv()), 32'(pat(exp_pos)));
      end
      do_step(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule